// File: doc/BRIEF.md
# Mode-Dependent Fault Encoder

This block sits between a set of independent fault detectors and the single fault pin of a read/write head preamplifier. It works out the operating mode from a two-bit mode register field and the read/write pin. It then keeps only the detector inputs that matter in that mode and turns the most urgent one into a four-bit code. The code is held until software next writes the mode register.

The fault pin is an open-collector line with an external pull-up, so the block only decides when to turn the pull-down on. The meaning of the pin flips with the mode. While writing, a fault lets the line float high. While reading, a fault pulls the line low. In sleep and standby the block never drives the line.

The block also checks the head-select value. Heads 0 to 11 are passed through unchanged. Any higher value sends the reader bias to a dummy head, and in read mode it also raises a fault.

Top module: `faultEncoder`

## Requirements
- R1: Mode decode: `modeBits` 00 is sleep and 01 is standby, whatever `rwPin` is. When `modeBits[1]` is 1 the block is active: reading if `rwPin` is 1, writing if `rwPin` is 0.
- R2: Read-mode codes: `wrCurInRead` gives 1, `thermalAsp` gives 3, `readHeadOpen` gives 4, `refPinBad` gives 5, `supplyLow` gives 6, and an illegal head gives 7. Code 0 means no fault. Code 2 is reserved and is never produced.
- R3: Write-mode codes: `refPinBad` gives 5, `supplyLow` gives 6, `writeHeadOpen` gives 8 and `writeDataIdle` gives 9. The read-only inputs (`wrCurInRead`, `thermalAsp`, `readHeadOpen`) and an illegal head have no effect on the code while writing.
- R4: While reading, `writeHeadOpen` and `writeDataIdle` have no effect on the code. In sleep and standby no detector input has any effect, and the code stays 0.
- R5: When several qualified faults are present at once, the lowest nonzero code is the one captured.
- R6: Once the held code is nonzero, it keeps its value on every later edge until it is cleared. This holds even if the fault goes away or other faults appear.
- R7: A `modeWrite` pulse sets the held code to 0 on that clock edge, even if faults are present in the same cycle. A fault that is still present is captured again on the following edge.
- R8: Pull-down drive: when reading, `flagPullDown` is 1 exactly when the held code is nonzero. When writing, it is 1 exactly when the held code is 0. In sleep or standby it is 0.
- R9: Head routing: if `headSel` is 0 to 11, `headOut` equals `headSel` and `dummySel` is 0. If `headSel` is 12 to 15, `headOut` is 0 and `dummySel` is 1, in every mode.
- R10: An illegal head (12 to 15) raises code 7 in read mode. Any lower qualified code takes precedence over it.
- R11: While `rst_n` is low, the held code is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| modeBits | input | 2 | Mode field from the mode register |
| rwPin | input | 1 | Read/write pin, 1 = read |
| modeWrite | input | 1 | One-cycle strobe: the mode register was written |
| headSel | input | 4 | Head-select value from the register |
| wrCurInRead | input | 1 | Detector: write current flowing |
| thermalAsp | input | 1 | Detector: thermal asperity |
| readHeadOpen | input | 1 | Detector: read element open |
| refPinBad | input | 1 | Detector: reference resistor pin open or shorted |
| supplyLow | input | 1 | Detector: either supply rail low |
| writeHeadOpen | input | 1 | Detector: write element open |
| writeDataIdle | input | 1 | Detector: no write data transitions |
| faultCode | output | 4 | Held fault code |
| flagPullDown | output | 1 | Enable for the fault pin pull-down |
| headOut | output | 4 | Head number sent to the head switch |
| dummySel | output | 1 | Reader bias steered to the dummy head |

## Verification
The bench goes after the inverted flag sense. A design with a single fixed polarity would drive the pull-down the same way in both modes and fail either the write rows or the read rows. It sweeps every head address in read mode and in write mode. A design with an off-by-one bound would treat head 11 as illegal or head 12 as legal, and a design that does not qualify the head fault by mode would report code 7 while writing. It feeds faults that belong to the other mode, and faults while the block sleeps, to catch a design that does not qualify its inputs. It then checks three behaviours of the held code: it stays put after the fault goes away and when another fault arrives; a clear in the same cycle as a live fault must win; and the fault must be captured again on the next cycle.

// File: rtl/faultEncPkg.sv
`timescale 1ns/1ps
package faultEncPkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] faultCode_t;

  localparam faultCode_t CODE_NONE    = 4'd0;
  localparam faultCode_t CODE_WCUR    = 4'd1;
  localparam faultCode_t CODE_RSVD    = 4'd2;
  localparam faultCode_t CODE_TA      = 4'd3;
  localparam faultCode_t CODE_RHEAD   = 4'd4;
  localparam faultCode_t CODE_REF     = 4'd5;
  localparam faultCode_t CODE_SUPPLY  = 4'd6;
  localparam faultCode_t CODE_BADHEAD = 4'd7;
  localparam faultCode_t CODE_WHEAD   = 4'd8;
  localparam faultCode_t CODE_WDATA   = 4'd9;

  typedef enum logic [1:0] {
    OP_SLEEP   = 2'd0,
    OP_STANDBY = 2'd1,
    OP_READ    = 2'd2,
    OP_WRITE   = 2'd3
  } opMode_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       clear;
    logic       isRead;
    logic       isWrite;
    logic       badHead;
    faultCode_t cand;
  } ctrlStrobe_t;
endpackage

// File: rtl/faultEncCtrl.sv
`timescale 1ns/1ps
module faultEncCtrl
  import faultEncPkg::*;
#(
  parameter int HEAD_W    = 4,
  parameter int NUM_HEADS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        modeBits,
  input  logic              rwPin,
  input  logic              modeWrite,
  input  logic [HEAD_W-1:0] headSel,
  input  logic              wrCurInRead,
  input  logic              thermalAsp,
  input  logic              readHeadOpen,
  input  logic              refPinBad,
  input  logic              supplyLow,
  input  logic              writeHeadOpen,
  input  logic              writeDataIdle,
  output ctrlStrobe_t       strobe
);
  localparam int NUM_CODES = 2 ** CODE_W;
  localparam logic [HEAD_W:0] HEAD_LIMIT = (HEAD_W+1)'(NUM_HEADS);

  opMode_t              opMode;
  logic                 badHead;
  logic [NUM_CODES-1:0] hit;
  faultCode_t           cand;

  // Mode decode: the mode field alone selects sleep or standby
  always_comb begin
    if (modeBits[1])      opMode = rwPin ? OP_READ : OP_WRITE;
    else if (modeBits[0]) opMode = OP_STANDBY;
    else                  opMode = OP_SLEEP;
  end

  assign badHead = {1'b0, headSel} >= HEAD_LIMIT;

  // Qualify the detectors by mode, one hit bit per code
  always_comb begin
    hit = '0;
    unique case (opMode)
      OP_READ: begin
        hit[CODE_WCUR]    = wrCurInRead;
        hit[CODE_TA]      = thermalAsp;
        hit[CODE_RHEAD]   = readHeadOpen;
        hit[CODE_REF]     = refPinBad;
        hit[CODE_SUPPLY]  = supplyLow;
        hit[CODE_BADHEAD] = badHead;
      end
      OP_WRITE: begin
        hit[CODE_REF]     = refPinBad;
        hit[CODE_SUPPLY]  = supplyLow;
        hit[CODE_WHEAD]   = writeHeadOpen;
        hit[CODE_WDATA]   = writeDataIdle;
      end
      default: hit = '0;
    endcase
  end

  // Lowest nonzero code wins: scan downward so the last match is the lowest
  always_comb begin
    cand = CODE_NONE;
    for (int c = NUM_CODES - 1; c >= 1; c--) begin
      if (hit[c]) cand = faultCode_t'(c);
    end
  end

  assign strobe.clear   = modeWrite;
  assign strobe.isRead  = (opMode == OP_READ);
  assign strobe.isWrite = (opMode == OP_WRITE);
  assign strobe.badHead = badHead;
  assign strobe.cand    = cand;

  // R2
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cand != CODE_RSVD);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBits == 2'b00 || modeBits == 2'b01) |-> strobe.cand == CODE_NONE);

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBits[1] && rwPin && wrCurInRead) |-> strobe.cand == CODE_WCUR);

  // R10
  bad_head_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBits[1] && rwPin && headSel >= HEAD_W'(NUM_HEADS)) |->
      (strobe.cand != CODE_NONE && strobe.cand <= CODE_BADHEAD));
endmodule

// File: rtl/faultEncDatapath.sv
`timescale 1ns/1ps
module faultEncDatapath
  import faultEncPkg::*;
#(
  parameter int HEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [HEAD_W-1:0] headSel,
  output faultCode_t        faultCode,
  output logic              flagPullDown,
  output logic [HEAD_W-1:0] headOut,
  output logic              dummySel
);
  faultCode_t heldCode;

  // Capture only while empty; clear wins over capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      heldCode <= CODE_NONE;
    else if (strobe.clear)           heldCode <= CODE_NONE;
    else if (heldCode == CODE_NONE)  heldCode <= strobe.cand;
  end

  // Open-collector drive: read flags low, write flags high
  always_comb begin
    if (strobe.isRead)       flagPullDown = (heldCode != CODE_NONE);
    else if (strobe.isWrite) flagPullDown = (heldCode == CODE_NONE);
    else                     flagPullDown = 1'b0;
  end

  assign dummySel  = strobe.badHead;
  assign headOut   = strobe.badHead ? '0 : headSel;
  assign faultCode = heldCode;

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> faultCode == CODE_NONE);

  // R6
  held_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (faultCode != CODE_NONE && !strobe.clear) |=> $stable(faultCode));

  // R8
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.isRead && !strobe.isWrite) |-> !flagPullDown);

  // R9
  dummy_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dummySel |-> headOut == '0);
endmodule

// File: rtl/faultEncoder.sv
`timescale 1ns/1ps
module faultEncoder
  import faultEncPkg::*;
#(
  parameter int HEAD_W    = 4,
  parameter int NUM_HEADS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        modeBits,
  input  logic              rwPin,
  input  logic              modeWrite,
  input  logic [HEAD_W-1:0] headSel,
  input  logic              wrCurInRead,
  input  logic              thermalAsp,
  input  logic              readHeadOpen,
  input  logic              refPinBad,
  input  logic              supplyLow,
  input  logic              writeHeadOpen,
  input  logic              writeDataIdle,
  output logic [3:0]        faultCode,
  output logic              flagPullDown,
  output logic [HEAD_W-1:0] headOut,
  output logic              dummySel
);
  ctrlStrobe_t strobe;

  faultEncCtrl #(.HEAD_W(HEAD_W), .NUM_HEADS(NUM_HEADS)) ctrl (
    .clk(clk), .rst_n(rst_n), .modeBits(modeBits), .rwPin(rwPin),
    .modeWrite(modeWrite), .headSel(headSel),
    .wrCurInRead(wrCurInRead), .thermalAsp(thermalAsp),
    .readHeadOpen(readHeadOpen), .refPinBad(refPinBad),
    .supplyLow(supplyLow), .writeHeadOpen(writeHeadOpen),
    .writeDataIdle(writeDataIdle), .strobe(strobe)
  );

  faultEncDatapath #(.HEAD_W(HEAD_W)) dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .headSel(headSel),
    .faultCode(faultCode), .flagPullDown(flagPullDown),
    .headOut(headOut), .dummySel(dummySel)
  );
endmodule

// File: tb/faultEncoder_test.sv
`timescale 1ns/1ps
module faultEncoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] modeBits = 2'b00;
  logic       rwPin = 1'b1;
  logic       modeWrite = 1'b0;
  logic [3:0] headSel = 4'd0;
  logic [6:0] flt = 7'h00;  // {wDataIdle, wHeadOpen, supply, ref, rHeadOpen, ta, wCur}
  logic [3:0] faultCode;
  logic       flagPullDown;
  logic [3:0] headOut;
  logic       dummySel;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  faultEncoder uut (
    .clk(clk), .rst_n(rst_n), .modeBits(modeBits), .rwPin(rwPin),
    .modeWrite(modeWrite), .headSel(headSel),
    .wrCurInRead(flt[0]), .thermalAsp(flt[1]), .readHeadOpen(flt[2]),
    .refPinBad(flt[3]), .supplyLow(flt[4]), .writeHeadOpen(flt[5]),
    .writeDataIdle(flt[6]),
    .faultCode(faultCode), .flagPullDown(flagPullDown),
    .headOut(headOut), .dummySel(dummySel)
  );

  // {mode, rw, head, faults, expCode, expPullDown, expHeadOut, expDummy}
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {2'b10, 1'b1, 4'd3,  7'h00, 4'd0, 1'b0, 4'd3,  1'b0},  // R2 read clean
    {2'b10, 1'b1, 4'd3,  7'h01, 4'd1, 1'b1, 4'd3,  1'b0},  // R2
    {2'b10, 1'b1, 4'd3,  7'h02, 4'd3, 1'b1, 4'd3,  1'b0},  // R2
    {2'b10, 1'b1, 4'd3,  7'h04, 4'd4, 1'b1, 4'd3,  1'b0},  // R2
    {2'b10, 1'b1, 4'd3,  7'h08, 4'd5, 1'b1, 4'd3,  1'b0},  // R2
    {2'b10, 1'b1, 4'd3,  7'h10, 4'd6, 1'b1, 4'd3,  1'b0},  // R2
    {2'b10, 1'b1, 4'd12, 7'h00, 4'd7, 1'b1, 4'd0,  1'b1},  // R10
    {2'b10, 1'b1, 4'd3,  7'h20, 4'd0, 1'b0, 4'd3,  1'b0},  // R4
    {2'b10, 1'b1, 4'd3,  7'h40, 4'd0, 1'b0, 4'd3,  1'b0},  // R4
    {2'b10, 1'b0, 4'd5,  7'h00, 4'd0, 1'b1, 4'd5,  1'b0},  // R8 write clean
    {2'b10, 1'b0, 4'd5,  7'h08, 4'd5, 1'b0, 4'd5,  1'b0},  // R3
    {2'b10, 1'b0, 4'd5,  7'h10, 4'd6, 1'b0, 4'd5,  1'b0},  // R3
    {2'b10, 1'b0, 4'd5,  7'h20, 4'd8, 1'b0, 4'd5,  1'b0},  // R3
    {2'b10, 1'b0, 4'd5,  7'h40, 4'd9, 1'b0, 4'd5,  1'b0},  // R3
    {2'b10, 1'b0, 4'd5,  7'h07, 4'd0, 1'b1, 4'd5,  1'b0},  // R3 read-only ignored
    {2'b10, 1'b0, 4'd13, 7'h00, 4'd0, 1'b1, 4'd0,  1'b1},  // R3 bad head ignored
    {2'b10, 1'b1, 4'd3,  7'h12, 4'd3, 1'b1, 4'd3,  1'b0},  // R5
    {2'b10, 1'b1, 4'd15, 7'h04, 4'd4, 1'b1, 4'd0,  1'b1},  // R10 lower wins
    {2'b00, 1'b1, 4'd3,  7'h7f, 4'd0, 1'b0, 4'd3,  1'b0},  // R1 sleep
    {2'b01, 1'b0, 4'd3,  7'h7f, 4'd0, 1'b0, 4'd3,  1'b0},  // R1 standby
    {2'b11, 1'b1, 4'd11, 7'h10, 4'd6, 1'b1, 4'd11, 1'b0},  // R1 mode 11 read
    {2'b11, 1'b0, 4'd2,  7'h60, 4'd8, 1'b0, 4'd2,  1'b0}   // R1 R5 mode 11 write
  };

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Clear for a cycle with no faults, then apply the faults and sample
  task automatic applyVec(logic [1:0] m, logic rw, logic [3:0] h, logic [6:0] f);
    @(negedge clk);
    modeBits = m; rwPin = rw; headSel = h; flt = 7'h00; modeWrite = 1'b1;
    @(negedge clk);
    modeWrite = 1'b0; flt = f;
    @(negedge clk);
  endtask

  initial begin
    // R11: reset holds the code at zero despite a live fault
    modeBits = 2'b10; rwPin = 1'b1; flt = 7'h02; headSel = 4'd1;
    repeat (3) @(negedge clk);
    check("R11", "code in reset", faultCode, 0);
    check("R8", "pulldown in reset", flagPullDown, 0);
    flt = 7'h00;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      applyVec(v[23:22], v[21], v[20:17], v[16:10]);
      check("R2", $sformatf("vec%0d code", i), faultCode, int'(v[9:6]));
      check("R8", $sformatf("vec%0d pulldown", i), flagPullDown, int'(v[5]));
      check("R9", $sformatf("vec%0d headOut", i), headOut, int'(v[4:1]));
      check("R9", $sformatf("vec%0d dummy", i), dummySel, int'(v[0]));
    end

    // R9 R10: every head address, read then write
    for (int h = 0; h < 16; h++) begin
      applyVec(2'b10, 1'b1, 4'(h), 7'h00);
      check("R10", $sformatf("read head %0d code", h), faultCode, (h >= 12) ? 7 : 0);
      check("R9", $sformatf("head %0d out", h), headOut, (h >= 12) ? 0 : h);
      check("R9", $sformatf("head %0d dummy", h), dummySel, (h >= 12) ? 1 : 0);
      applyVec(2'b10, 1'b0, 4'(h), 7'h00);
      check("R3", $sformatf("write head %0d code", h), faultCode, 0);
      check("R9", $sformatf("write head %0d dummy", h), dummySel, (h >= 12) ? 1 : 0);
    end

    // R6: hold after the fault goes away and when another arrives
    applyVec(2'b10, 1'b1, 4'd2, 7'h02);
    check("R6", "captured TA", faultCode, 3);
    flt = 7'h00;
    @(negedge clk);
    check("R6", "held after removal", faultCode, 3);
    flt = 7'h01;
    @(negedge clk);
    check("R6", "held against new fault", faultCode, 3);
    // R8: held code seen through write and sleep
    rwPin = 1'b0;
    @(negedge clk);
    check("R8", "write with fault pulldown", flagPullDown, 0);
    check("R6", "held across mode", faultCode, 3);
    modeBits = 2'b00;
    @(negedge clk);
    check("R8", "sleep pulldown", flagPullDown, 0);
    // R7: clear wins over a live fault, then recapture
    modeBits = 2'b10; rwPin = 1'b1; modeWrite = 1'b1;
    @(negedge clk);
    check("R7", "clear with live fault", faultCode, 0);
    modeWrite = 1'b0;
    @(negedge clk);
    check("R7", "recapture after clear", faultCode, 1);
    check("R8", "read fault pulldown", flagPullDown, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule